// File: doc/BRIEF.md
# Hardware Ticket Lock

This block is a shared lock that hands ownership to a fixed set of requesters strictly in the order in which they asked for it. It holds two counters. A dispensing counter supplies the next ticket number. A serving counter names the ticket that may own the lock now. A requester pulses its take strobe and receives the dispensing value as it stood before the increment. The requester keeps that number in its own slot and waits until the serving counter reaches it. The owner then pulses its release strobe, the serving counter advances by one, and ownership passes to the next ticket in line.

Each requester slot is a small state machine with three states. `SLOT_IDLE` means no ticket is held. `SLOT_WAIT` means a ticket is held and the lock is not yet owned. `SLOT_OWN` means the slot holds the grant. The transitions are: *take* (`SLOT_IDLE`→`SLOT_WAIT` on an accepted strobe, loading the offered ticket), *match* (`SLOT_WAIT`→`SLOT_OWN` when the held ticket equals the serving counter) and *release* (`SLOT_OWN`→`SLOT_IDLE` on the slot's own release strobe). In every other case a slot stays in its state. When several idle requesters strobe in the same cycle, the dispenser numbers them consecutively, lowest index first. Both counters wrap modulo 2^`TKT_W`. The default width is one bit more than needed to number the requesters, so tickets stay unique across wraparound.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset, every grant, `busy_o` and `rel_err_o` read 0, and every ticket field reads 0.
- R2: A take strobe from an idle requester loads its ticket field (slot i at bits [i*TKT_W +: TKT_W] of `ticket_o`) with the dispensing counter's value before the increment. The field is visible after the same clock edge.
- R3: Idle requesters that strobe take in the same cycle receive consecutive tickets in ascending index order. The dispensing counter advances by the number accepted.
- R4: A waiting requester's grant rises one cycle after the cycle in which its ticket equals the serving counter. A ticket taken while the unit is free is therefore granted on the second edge after the strobe.
- R5: A release strobe from the grant holder drops that grant and advances the serving counter by one at the same edge.
- R6: Grants are given in the order in which tickets were taken.
- R7: At most one grant output is high in any cycle.
- R8: A release strobe from a requester that does not hold the grant changes no grant and no counter. It sets `rel_err_o`, which stays set until reset.
- R9: A take strobe from a requester that already holds a ticket (waiting or owning) is ignored. Its ticket field is unchanged and no ticket is consumed.
- R10: Ticket order and grant matching stay correct after both counters wrap.
- R11: `busy_o` is high exactly when the dispensing and serving counters differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | N_REQ | Per-requester take-ticket strobe |
| release_i | input | N_REQ | Per-requester release strobe |
| grant_o | output | N_REQ | Per-requester lock grant |
| ticket_o | output | N_REQ*TKT_W | Held ticket of each slot, packed by index |
| busy_o | output | 1 | Lock held or tickets outstanding |
| rel_err_o | output | 1 | Sticky flag for a release from a non-holder |

## Verification
Ticket fields, counter effects, `busy_o` and `rel_err_o` respond at the first clock edge after a strobe. A grant follows one edge after its ticket meets the serving value, so on a free unit it appears two edges after the take. A released grant drops at the release edge. The successor's grant rises one edge later. The bench drives inputs on the falling edge and advances its own model of the counters and slot states at each rising edge. It compares every output at the next falling edge, so each delay is checked cycle by cycle.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_OWN  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/tl_ticket_dispenser.sv
module tl_ticket_dispenser #(
    parameter int N_REQ = 4,
    parameter int TKT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       take_ok,
    output logic [N_REQ*TKT_W-1:0] offer_flat,
    output logic [TKT_W-1:0]       next_q
);
    logic [TKT_W-1:0] offset [N_REQ+1];
    logic [TKT_W-1:0] next_d;

    // Prefix count of accepted takers; lower index gets the lower ticket
    assign offset[0] = '0;
    generate
        for (genvar g = 0; g < N_REQ; g++) begin : g_offer
            assign offer_flat[g*TKT_W +: TKT_W] = next_q + offset[g];
            assign offset[g+1] = offset[g] + (take_ok[g] ? TKT_W'(1) : TKT_W'(0));
        end
    endgenerate

    assign next_d = next_q + offset[N_REQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) next_q <= '0;
        else        next_q <= next_d;
    end

    // R9
    no_take_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ok == '0) |=> $stable(next_q));
endmodule

// File: rtl/tl_serve_counter.sv
module tl_serve_counter #(
    parameter int N_REQ = 4,
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] release_i,
    input  logic [N_REQ-1:0] own_vec,
    output logic [TKT_W-1:0] serving_q,
    output logic             err_q
);
    logic good_rel;
    logic bad_rel;

    assign good_rel = |(release_i & own_vec);
    assign bad_rel  = |(release_i & ~own_vec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serving_q <= '0;
            err_q     <= 1'b0;
        end else begin
            if (good_rel) serving_q <= serving_q + TKT_W'(1);
            if (bad_rel)  err_q     <= 1'b1;
        end
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R5
    serve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((release_i & own_vec) == '0) |=> $stable(serving_q));
endmodule

// File: rtl/tl_holder_slot.sv
module tl_holder_slot
    import ticket_lock_pkg::*;
#(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_ok,
    input  logic             release_i,
    input  logic [TKT_W-1:0] offer_tkt,
    input  logic [TKT_W-1:0] serving,
    output logic             idle_o,
    output logic             own_o,
    output logic [TKT_W-1:0] ticket_o
);
    slot_state_e      state_q, state_d;
    logic [TKT_W-1:0] ticket_q;
    logic             load;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SLOT_IDLE: if (take_ok) begin
                state_d = SLOT_WAIT;
                load    = 1'b1;
            end
            SLOT_WAIT: if (ticket_q == serving) state_d = SLOT_OWN;
            SLOT_OWN:  if (release_i)           state_d = SLOT_IDLE;
            default:   state_d = SLOT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SLOT_IDLE;
            ticket_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) ticket_q <= offer_tkt;
        end
    end

    // Outputs
    always_comb begin
        idle_o   = (state_q == SLOT_IDLE);
        own_o    = (state_q == SLOT_OWN);
        ticket_o = ticket_q;
    end

    // R4
    owner_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_o |-> (ticket_q == serving));
    // R4
    grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_o) |-> $past(ticket_q == serving));
    // R9
    held_ticket_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |=> $stable(ticket_q));
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
    parameter int N_REQ = 4,
    parameter int TKT_W = $clog2(N_REQ) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       take_i,
    input  logic [N_REQ-1:0]       release_i,
    output logic [N_REQ-1:0]       grant_o,
    output logic [N_REQ*TKT_W-1:0] ticket_o,
    output logic                   busy_o,
    output logic                   rel_err_o
);
    logic [N_REQ-1:0]       idle_vec;
    logic [N_REQ-1:0]       own_vec;
    logic [N_REQ-1:0]       take_ok;
    logic [N_REQ*TKT_W-1:0] offer_flat;
    logic [TKT_W-1:0]       next_q;
    logic [TKT_W-1:0]       serving_q;

    assign take_ok = take_i & idle_vec;

    tl_ticket_dispenser #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_ok    (take_ok),
        .offer_flat (offer_flat),
        .next_q     (next_q)
    );

    tl_serve_counter #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_serve (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (release_i),
        .own_vec   (own_vec),
        .serving_q (serving_q),
        .err_q     (rel_err_o)
    );

    generate
        for (genvar g = 0; g < N_REQ; g++) begin : g_slot
            tl_holder_slot #(.TKT_W(TKT_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .take_ok   (take_ok[g]),
                .release_i (release_i[g]),
                .offer_tkt (offer_flat[g*TKT_W +: TKT_W]),
                .serving   (serving_q),
                .idle_o    (idle_vec[g]),
                .own_o     (own_vec[g]),
                .ticket_o  (ticket_o[g*TKT_W +: TKT_W])
            );
        end
    endgenerate

    assign grant_o = own_vec;
    assign busy_o  = (next_q != serving_q);

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(|(release_i & grant_o)));
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(|(take_i & idle_vec)));
endmodule

// File: tb/tb_ticket_lock_unit.sv
module tb_ticket_lock_unit;
    localparam int N = 4;
    localparam int W = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   take_i = '0;
    logic [N-1:0]   release_i = '0;
    logic [N-1:0]   grant_o;
    logic [N*W-1:0] ticket_o;
    logic           busy_o;
    logic           rel_err_o;

    int vectors = 0;
    int miscmp  = 0;

    // Bench model: 0 idle, 1 waiting, 2 owner
    int           m_st  [N];
    logic [W-1:0] m_tkt [N];
    logic [W-1:0] m_next, m_serv;
    bit           m_err;

    always #5 clk = ~clk;

    ticket_lock_unit #(.N_REQ(N), .TKT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .release_i(release_i),
        .grant_o(grant_o), .ticket_o(ticket_o), .busy_o(busy_o),
        .rel_err_o(rel_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_grant();
        logic [N-1:0] g = '0;
        for (int i = 0; i < N; i++) g[i] = (m_st[i] == 2);
        return g;
    endfunction

    function automatic logic [N-1:0] owner_mask();
        return exp_grant();
    endfunction

    // Advance the model by one clock edge per the requirements
    task automatic model_edge(input logic [N-1:0] tk, input logic [N-1:0] rl);
        logic [W-1:0] off = '0;
        bit adv = 0;
        for (int i = 0; i < N; i++) begin
            if (rl[i] && m_st[i] == 2) adv = 1;
            if (rl[i] && m_st[i] != 2) m_err = 1;
        end
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 0) begin
                if (tk[i]) begin
                    m_tkt[i] = m_next + off;
                    off = off + 1'b1;
                    m_st[i] = 1;
                end
            end else if (m_st[i] == 1) begin
                if (m_tkt[i] == m_serv) m_st[i] = 2;
            end else if (rl[i]) begin
                m_st[i] = 0;
            end
        end
        m_next = m_next + off;
        if (adv) m_serv = m_serv + 1'b1;
    endtask

    task automatic check_all();
        for (int i = 0; i < N; i++)
            chk("R2 R3 R9 ticket", int'(ticket_o[i*W +: W]), int'(m_tkt[i]));
        chk("R4 R5 R6 R10 grant", int'(grant_o), int'(exp_grant()));
        chk("R7 onehot", int'($countones(grant_o) <= 1), 1);
        chk("R11 busy", int'(busy_o), int'(m_next != m_serv));
        chk("R8 error flag", int'(rel_err_o), int'(m_err));
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic step(input logic [N-1:0] tk, input logic [N-1:0] rl);
        take_i = tk;
        release_i = rl;
        @(posedge clk);
        #1;
        model_edge(tk, rl);
        @(negedge clk);
        take_i = '0;
        release_i = '0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        logic [N-1:0] tk, rl, own;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_tkt[i] = '0; end
        m_next = '0; m_serv = '0; m_err = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 grant", int'(grant_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 err", int'(rel_err_o), 0);
        chk("R1 tickets", int'(ticket_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 then R4: lone taker on a free unit, granted two edges later
        step(4'b0100, '0);
        chk("R2 first ticket", int'(ticket_o[2*W +: W]), 0);
        chk("R4 not yet granted", int'(grant_o), 0);
        step('0, '0);
        chk("R4 granted", int'(grant_o), 4'b0100);

        // R3 and R9: all strobe together; owner slot 2 is ignored
        step(4'b1111, '0);
        chk("R3 slot0", int'(ticket_o[0 +: W]), 1);
        chk("R3 slot1", int'(ticket_o[W +: W]), 2);
        chk("R3 slot3", int'(ticket_o[3*W +: W]), 3);
        chk("R9 owner ticket kept", int'(ticket_o[2*W +: W]), 0);

        // R5 and R6: releases pass ownership 2 -> 0 -> 1 -> 3
        step('0, 4'b0100);
        chk("R5 grant dropped", int'(grant_o), 0);
        step('0, '0);
        chk("R6 next owner slot0", int'(grant_o), 4'b0001);
        step('0, 4'b0001);
        step('0, '0);
        chk("R6 next owner slot1", int'(grant_o), 4'b0010);
        step('0, 4'b0010);
        step('0, '0);
        chk("R6 next owner slot3", int'(grant_o), 4'b1000);
        step('0, 4'b1000);
        chk("R11 idle after last release", int'(busy_o), 0);

        // Random traffic with legal releases; counters wrap often (R10)
        for (int c = 0; c < 4000; c++) begin
            tk = N'($urandom) & N'($urandom);
            own = owner_mask();
            rl = ($urandom_range(0, 2) != 0) ? own : '0;
            step(tk, rl);
        end

        // R8: release from non-holders is ignored and flagged
        step(4'b0001, '0);
        step('0, '0);
        step('0, '0);
        own = owner_mask();
        step('0, ~own);
        chk("R8 grant unchanged", int'(grant_o), int'(own));
        chk("R8 flag set", int'(rel_err_o), 1);
        step('0, '0);
        chk("R8 flag sticky", int'(rel_err_o), 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule